// File: doc/BRIEF.md
# Line Alarm Status with Simulation Mode

This block gathers the alarm indications of one line receiver (loss of signal, alarm indication signal, and code-violation pulses from the line decoder) into live status bits, sticky interrupt status bits, a saturating code-violation counter and one interrupt line. Software reads the sticky bits and the counter through two read strobes; each read clears what it returned. A per-bit mask decides which pending bits may drive the interrupt line.

A simulation control input lets software test the whole reporting chain without a faulty line. While it is high, loss of signal and alarm indication are forced active and a code violation is injected on every clock. The real receiver indications are ignored during that time. The injected events use the same status latches and the same counter as real events. When simulation is switched off, the forced conditions vanish at once. Sticky bits that were raised stay pending until software reads them. The block sits beside the received data path and never alters it.

Top module: `line_alarm_status`

## Requirements
- R1: While `rstN` is low, `intStat`, `liveStat` and `cvCount` are zero and `irq` is low.
- R2: With simulation off, `liveStat[0]` (loss of signal) and `liveStat[1]` (alarm indication) equal `losRaw` and `aisRaw` as sampled at the previous rising clock edge. They clear by themselves once the input drops.
- R3: While `simEnable` is high, both `liveStat` bits read 1 one cycle later whatever `losRaw`, `aisRaw` and `cvPulse` do. The real inputs have no effect on any output during that time.
- R4: A 0-to-1 change of the effective loss-of-signal or alarm-indication level sets `intStat[0]` or `intStat[1]`. Every cycle with an effective code violation sets `intStat[2]`. A set bit stays set until it is read.
- R5: A cycle with `rdIntStat` high clears `intStat` at the next edge. An event in that same cycle is kept and its bit reads 1 afterwards.
- R6: With simulation off, `cvCount` rises by one for each cycle in which `cvPulse` is high. It stops at 16'hFFFF.
- R7: While `simEnable` is high, `cvCount` rises by one every clock and also stops at 16'hFFFF.
- R8: A cycle with `rdCvCount` high sets `cvCount` to 0 at the next edge. If a code violation occurs in that same cycle, `cvCount` is set to 1 instead.
- R9: After `simEnable` falls, the live bits follow the real inputs again from the next edge on. Sticky bits raised during simulation stay set until `rdIntStat` is pulsed.
- R10: `irq` is high exactly when some `intStat` bit is 1 while its `intMask` bit is 0. A mask bit of 1 suppresses that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| simEnable | input | 1 | Alarm simulation control bit |
| losRaw | input | 1 | Real loss-of-signal indication from the receiver |
| aisRaw | input | 1 | Real alarm-indication-signal indication from the receiver |
| cvPulse | input | 1 | One-cycle code-violation pulse from the line decoder |
| rdIntStat | input | 1 | Read strobe of the interrupt status register (clear on read) |
| rdCvCount | input | 1 | Read strobe of the code-violation counter (clear on read) |
| intMask | input | 3 | Interrupt mask; 1 suppresses the matching `intStat` bit |
| intStat | output | 3 | Sticky status: bit 0 loss of signal, bit 1 alarm indication, bit 2 code violation |
| liveStat | output | 2 | Live status: bit 0 loss of signal, bit 1 alarm indication |
| cvCount | output | 16 | Saturating code-violation counter |
| irq | output | 1 | Interrupt, OR of the unmasked pending status bits |

## Verification
A wrong edge-detect register shows within one cycle, as a missing or extra sticky bit. If the bench did not check every cycle, it could stay hidden until the next read. Because of that, the bench compares all outputs against a behavioural model after every clock. A dropped same-cycle event in a clear-on-read shows on the very next cycle, as a zero where the model holds a one. A counter that wraps instead of saturating shows only after 65,535 injected violations. For that reason one long simulation run drives the counter past its limit. A simulation flag that leaks past its end shows as live bits still set in the cycle after `simEnable` falls.

// File: rtl/las_pkg.sv
package las_pkg;
  localparam int NUM_LVL = 2;
  localparam int NUM_EVT = 3;

  typedef struct packed {
    logic [NUM_LVL-1:0] lvl;
    logic [NUM_EVT-1:0] ev;
    logic               clrStat;
    logic               clrCnt;
  } lasStrobe_t;
endpackage

// File: rtl/las_ctrl.sv
module las_ctrl
  import las_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               simEnable,
  input  logic               losRaw,
  input  logic               aisRaw,
  input  logic               cvPulse,
  input  logic               rdIntStat,
  input  logic               rdCvCount,
  output lasStrobe_t         strb,
  output logic [NUM_LVL-1:0] liveStat
);
  logic [NUM_LVL-1:0] effLvl;
  logic [NUM_LVL-1:0] liveQ;
  logic               cvHit;

  always_comb begin
    effLvl = simEnable ? {NUM_LVL{1'b1}} : {aisRaw, losRaw};
    cvHit  = simEnable | cvPulse;
    strb.lvl     = effLvl;
    strb.ev      = {cvHit, effLvl & ~liveQ};
    strb.clrStat = rdIntStat;
    strb.clrCnt  = rdCvCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveQ <= '0;
    else       liveQ <= effLvl;
  end

  assign liveStat = liveQ;

  // R3
  sim_forces_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    simEnable |=> (liveStat == {NUM_LVL{1'b1}}));

  // R2
  los_self_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!simEnable && !losRaw) |=> !liveStat[0]);
endmodule

// File: rtl/las_datapath.sv
module las_datapath
  import las_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  lasStrobe_t         strb,
  input  logic [NUM_EVT-1:0] intMask,
  output logic [NUM_EVT-1:0] intStat,
  output logic [CNT_W-1:0]   cvCount,
  output logic               irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int               CV_BIT  = NUM_EVT - 1;

  logic [NUM_EVT-1:0] statQ;
  logic [CNT_W-1:0]   cntQ;

  for (genvar b = 0; b < NUM_EVT; b++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statQ[b] <= 1'b0;
      else       statQ[b] <= (statQ[b] & ~strb.clrStat) | strb.ev[b];
    end

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (statQ[b] && !strb.clrStat) |=> statQ[b]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 cntQ <= '0;
    else if (strb.clrCnt)                      cntQ <= CNT_W'(strb.ev[CV_BIT]);
    else if (strb.ev[CV_BIT] && cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
  end

  assign intStat = statQ;
  assign cvCount = cntQ;
  assign irq     = |(statQ & ~intMask);

  // R5
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStat && strb.ev == '0) |=> (intStat == '0));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cvCount == CNT_MAX && !strb.clrCnt) |=> (cvCount == CNT_MAX));

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clrCnt && strb.ev[CV_BIT] && cvCount != CNT_MAX)
      |=> (cvCount == $past(cvCount) + CNT_W'(1)));

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrCnt && !strb.ev[CV_BIT]) |=> (cvCount == '0));
endmodule

// File: rtl/line_alarm_status.sv
module line_alarm_status
  import las_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               simEnable,
  input  logic               losRaw,
  input  logic               aisRaw,
  input  logic               cvPulse,
  input  logic               rdIntStat,
  input  logic               rdCvCount,
  input  logic [2:0]         intMask,
  output logic [2:0]         intStat,
  output logic [1:0]         liveStat,
  output logic [CNT_W-1:0]   cvCount,
  output logic               irq
);
  lasStrobe_t strb;

  las_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .simEnable (simEnable),
    .losRaw    (losRaw),
    .aisRaw    (aisRaw),
    .cvPulse   (cvPulse),
    .rdIntStat (rdIntStat),
    .rdCvCount (rdCvCount),
    .strb      (strb),
    .liveStat  (liveStat)
  );

  las_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .intMask (intMask),
    .intStat (intStat),
    .cvCount (cvCount),
    .irq     (irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (intStat == '0 && liveStat == '0 && cvCount == '0 && !irq));
endmodule

// File: tb/line_alarm_status_test.sv
module line_alarm_status_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        simEnable = 1'b0, losRaw = 1'b0, aisRaw = 1'b0, cvPulse = 1'b0;
  logic        rdIntStat = 1'b0, rdCvCount = 1'b0;
  logic [2:0]  intMask = 3'b000;
  logic [2:0]  intStat;
  logic [1:0]  liveStat;
  logic [15:0] cvCount;
  logic        irq;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string phase = "R1";

  int mInt  = 0;
  int mLive = 0;
  int mCnt  = 0;

  always #10 clk = ~clk;

  line_alarm_status uut (
    .clk(clk), .rstN(rstN), .simEnable(simEnable), .losRaw(losRaw),
    .aisRaw(aisRaw), .cvPulse(cvPulse), .rdIntStat(rdIntStat),
    .rdCvCount(rdCvCount), .intMask(intMask), .intStat(intStat),
    .liveStat(liveStat), .cvCount(cvCount), .irq(irq)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", phase, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference model, compared every clock
  always @(posedge clk) begin
    int los, ais, cv, rise;
    if (!rstN) begin
      mInt = 0; mLive = 0; mCnt = 0;
    end else begin
      los = simEnable ? 1 : int'(losRaw);
      ais = simEnable ? 1 : int'(aisRaw);
      cv  = simEnable ? 1 : int'(cvPulse);
      rise = 0;
      if (los == 1 && (mLive % 2) == 0) rise += 1;
      if (ais == 1 && (mLive / 2) == 0) rise += 2;
      if (rdIntStat) mInt = 0;
      mInt = mInt | rise | (cv * 4);
      if (rdCvCount) mCnt = cv;
      else if (cv == 1 && mCnt < 65535) mCnt++;
      mLive = los + 2 * ais;
    end
    #2;
    if (!done) begin
      chk("intStat",  int'(intStat),  mInt);
      chk("liveStat", int'(liveStat), mLive);
      chk("cvCount",  int'(cvCount),  mCnt);
      chk("irq",      int'(irq),      ((mInt & ~int'(intMask)) & 7) != 0 ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc(3);
    chk("reset intStat", int'(intStat), 0);
    chk("reset cvCount", int'(cvCount), 0);
    chk("reset irq", int'(irq), 0);
    rstN = 1'b1;
    cyc(2);

    // R2: live bits follow real inputs and self-clear
    phase = "R2";
    losRaw = 1'b1; cyc(3); losRaw = 1'b0; cyc(2);
    aisRaw = 1'b1; cyc(2); aisRaw = 1'b0; cyc(2);

    // R4: sticky bits hold, repeated rise
    phase = "R4";
    cyc(3);
    losRaw = 1'b1; cyc(1); losRaw = 1'b0; cyc(2);

    // R5: read clears, same-cycle event kept
    phase = "R5";
    rdIntStat = 1'b1; cyc(1); rdIntStat = 1'b0; cyc(2);
    rdIntStat = 1'b1; losRaw = 1'b1; cyc(1); rdIntStat = 1'b0; cyc(2);
    losRaw = 1'b0; rdIntStat = 1'b1; cyc(1); rdIntStat = 1'b0; cyc(1);

    // R6: counting decoder pulses
    phase = "R6";
    for (int i = 0; i < 12; i++) begin
      cvPulse = (i % 3 == 0); cyc(1);
    end
    cvPulse = 1'b0; cyc(1);

    // R8: clear-on-read of the counter, with and without a same-cycle pulse
    phase = "R8";
    rdCvCount = 1'b1; cvPulse = 1'b1; cyc(1);
    rdCvCount = 1'b0; cvPulse = 1'b0; cyc(2);
    rdCvCount = 1'b1; cyc(1); rdCvCount = 1'b0; cyc(1);

    // R10: masking of the interrupt line
    phase = "R10";
    rdIntStat = 1'b1; cyc(1); rdIntStat = 1'b0;
    intMask = 3'b111; cvPulse = 1'b1; cyc(1); cvPulse = 1'b0; cyc(2);
    intMask = 3'b011; cyc(2);
    intMask = 3'b100; cyc(1);
    aisRaw = 1'b1; cyc(2); aisRaw = 1'b0;
    rdIntStat = 1'b1; cyc(1); rdIntStat = 1'b0; intMask = 3'b000; cyc(1);

    // R3: simulation forces alarms, real inputs masked
    phase = "R3";
    simEnable = 1'b1;
    for (int i = 0; i < 20; i++) begin
      losRaw = i[0]; aisRaw = i[1]; cvPulse = i[2];
      if (i == 9) rdIntStat = 1'b1; else rdIntStat = 1'b0;
      cyc(1);
    end
    losRaw = 1'b0; aisRaw = 1'b0; cvPulse = 1'b0; rdIntStat = 1'b0;

    // R9: leaving simulation, sticky bits remain until read
    phase = "R9";
    simEnable = 1'b0; cyc(4);
    aisRaw = 1'b1; cyc(2); aisRaw = 1'b0;
    rdIntStat = 1'b1; cyc(1); rdIntStat = 1'b0;
    rdCvCount = 1'b1; cyc(1); rdCvCount = 1'b0; cyc(2);

    // R7: one increment per clock in simulation
    phase = "R7";
    simEnable = 1'b1; cyc(100);
    rdCvCount = 1'b1; cyc(1); rdCvCount = 1'b0; cyc(10);

    // R6: saturation at all ones
    phase = "R6";
    cyc(65600);
    chk("saturated cvCount", int'(cvCount), 65535);
    simEnable = 1'b0; cyc(3);
    cvPulse = 1'b1; cyc(2); cvPulse = 1'b0;
    rdCvCount = 1'b1; cyc(1); rdCvCount = 1'b0; cyc(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule